// File: doc/BRIEF.md
# USB Single-Ended Line-State Encoder and Receive Logic

This block is the digital core between a USB full-speed/low-speed controller that works in single-ended mode and the analog line drivers and receivers. On the transmit side it turns the controller's data bit and force-SE0 bit into the two D+/D- drive levels. A drive-enable output goes with them, and it follows the active-low output-enable input. On the receive side it takes sampled D+/D- levels and produces three outputs: the differential receive bit and the two single-ended line bits.

The receive bit is kept in a hold register that loads only on a J or K line state, so it carries its last value through single-ended-zero periods. The receive bit reads zero while suspend is requested, but the single-ended bits keep following the bus so that resume signalling stays visible.

Two flags report whether the I/O supply and the 3.3 V supply are present. When the 3.3 V supply is missing, the receive outputs show a fixed sharing pattern. The Hi-Z input and a missing I/O supply release every output group. High impedance is shown as one output-enable per group rather than as tri-state nets. After suspend or Hi-Z ends, a guard counter keeps a receive-valid flag low for a time derived from the clock period. All outputs are registered, so each one reflects the inputs sampled at the previous rising clock edge.

Top module: `usb_linestate_xcvr`

## Requirements
- R1: With the line driver enabled, force-SE0 high gives drive levels D+=0, D-=0 whatever the data bit is. With force-SE0 low, data 1 gives D+=1, D-=0 and data 0 gives D+=0, D-=1.
- R2: The drive enable is high only in normal supply mode (both supplies present, Hi-Z input low) with the active-low output enable low. While the drive enable is low, both drive levels read 0.
- R3: In normal supply mode the receive output-enable is high, and the single-ended outputs equal the sampled D+ and D- levels. This also holds during suspend.
- R4: In normal mode without suspend, a J or K line state (sampled D+ differs from D-) sets the receive bit to the sampled D+ level.
- R5: In normal mode without suspend, a line state with D+ equal to D- (SE0, or both high) leaves the receive bit at the value the hold register last loaded on a J or K state. The hold register does not load during suspend, sharing, Hi-Z or disable.
- R6: In normal mode with suspend high, the receive bit reads 0 while the single-ended outputs still follow the bus.
- R7: With the I/O supply present, the 3.3 V supply absent and Hi-Z low (sharing mode), both single-ended outputs read 1, the receive bit reads 0, the receive output-enable is high and the drive enable is low.
- R8: With the I/O supply present and Hi-Z high, the drive enable and the receive output-enable are low, and the receive-side outputs read 0.
- R9: With the I/O supply absent, the drive enable and the receive output-enable are low, whatever Hi-Z is.
- R10: The receive-valid flag is low at every edge where suspend or Hi-Z is sampled high, and at the first GUARD_CYC edges after both are sampled low, or after reset ends. It reads 1 after the (GUARD_CYC+1)th such edge. GUARD_CYC = ceil(GUARD_NS*1000 / CLK_PERIOD_PS).
- R11: While reset is high, every output, including the receive-valid flag, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_oe_n | input | 1 | Active-low line-driver enable request |
| tx_data | input | 1 | Transmit data bit |
| tx_se0 | input | 1 | Force single-ended zero on transmit |
| bus_dp | input | 1 | Sampled D+ level |
| bus_dm | input | 1 | Sampled D- level |
| suspend | input | 1 | Suspend request |
| hiz | input | 1 | High-impedance request |
| vio_ok | input | 1 | I/O supply present |
| v33_ok | input | 1 | 3.3 V supply present |
| drv_en | output | 1 | D+/D- driver enable |
| drv_dp | output | 1 | D+ drive level |
| drv_dm | output | 1 | D- drive level |
| rx_oe | output | 1 | Output enable for rcv, se_dp and se_dm |
| rcv | output | 1 | Differential receive bit |
| se_dp | output | 1 | Single-ended D+ receive bit |
| se_dm | output | 1 | Single-ended D- receive bit |
| rcv_valid | output | 1 | Receive bit valid after the guard time |

## Verification
The bench builds the block with CLK_PERIOD_PS=4000 and GUARD_NS=100, which gives a 25-cycle guard. That window is short enough to count out edge by edge three times: after reset, after suspend and after Hi-Z. The bench checks that the flag is still low at edge 25 and high at edge 26. The walked vector table reaches every supply mode from one hold-register history. This exposes a stale receive value that was carried across suspend, sharing and Hi-Z and then shown again on a later SE0.

// File: rtl/usb_ls_pkg.sv
package usb_ls_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SHARE  = 2'd1,
    MODE_HIZ    = 2'd2,
    MODE_OFF    = 2'd3
  } supply_mode_e;

  // Priority: missing I/O supply, then Hi-Z request, then missing 3.3 V.
  function automatic supply_mode_e decode_mode(input logic vio_ok,
                                               input logic v33_ok,
                                               input logic hiz);
    if (!vio_ok)      return MODE_OFF;
    else if (hiz)     return MODE_HIZ;
    else if (!v33_ok) return MODE_SHARE;
    else              return MODE_NORMAL;
  endfunction

  function automatic int unsigned guard_cycles(input int unsigned guard_ns,
                                               input int unsigned clk_ps);
    return (guard_ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/usb_ls_tx_enc.sv
module usb_ls_tx_enc
  import usb_ls_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  supply_mode_e mode_i,
  input  logic         oe_n_i,
  input  logic         data_i,
  input  logic         se0_i,
  output logic         drv_en_o,
  output logic         dp_o,
  output logic         dm_o
);

  logic en;
  assign en = (mode_i == MODE_NORMAL) && !oe_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_en_o <= 1'b0;
      dp_o     <= 1'b0;
      dm_o     <= 1'b0;
    end else begin
      drv_en_o <= en;
      dp_o     <= en && !se0_i && data_i;
      dm_o     <= en && !se0_i && !data_i;
    end
  end

  p_se0_levels_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && en && se0_i) |-> (!dp_o && !dm_o));

  p_diff_levels_r1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && en && !se0_i) |-> (dp_o == $past(data_i)) && (dm_o != dp_o));

  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (rst)
    !drv_en_o |-> (!dp_o && !dm_o));

endmodule

// File: rtl/usb_ls_rx_dec.sv
module usb_ls_rx_dec
  import usb_ls_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  supply_mode_e mode_i,
  input  logic         suspend_i,
  input  logic         dp_i,
  input  logic         dm_i,
  output logic         rx_oe_o,
  output logic         vp_o,
  output logic         vm_o,
  output logic         rcv_o
);

  logic live;
  logic jk;
  logic hold_q;

  assign live = (mode_i == MODE_NORMAL) && !suspend_i;
  assign jk   = dp_i ^ dm_i;

  always_ff @(posedge clk) begin
    if (rst)             hold_q <= 1'b0;
    else if (live && jk) hold_q <= dp_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_oe_o <= 1'b0;
      vp_o    <= 1'b0;
      vm_o    <= 1'b0;
      rcv_o   <= 1'b0;
    end else begin
      unique case (mode_i)
        MODE_NORMAL: begin
          rx_oe_o <= 1'b1;
          vp_o    <= dp_i;
          vm_o    <= dm_i;
          rcv_o   <= suspend_i ? 1'b0 : (jk ? dp_i : hold_q);
        end
        MODE_SHARE: begin
          rx_oe_o <= 1'b1;
          vp_o    <= 1'b1;
          vm_o    <= 1'b1;
          rcv_o   <= 1'b0;
        end
        default: begin
          rx_oe_o <= 1'b0;
          vp_o    <= 1'b0;
          vm_o    <= 1'b0;
          rcv_o   <= 1'b0;
        end
      endcase
    end
  end

  p_hold_through_se0_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst, 2) && $past(live, 2) && $past(live && !jk)) |-> $stable(rcv_o));

  p_suspend_low_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && mode_i == MODE_NORMAL && suspend_i) |->
      (!rcv_o && vp_o == $past(dp_i) && vm_o == $past(dm_i)));

  p_share_pattern_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && mode_i == MODE_SHARE) |-> (rx_oe_o && vp_o && vm_o && !rcv_o));

endmodule

// File: rtl/usb_ls_rx_guard.sv
module usb_ls_rx_guard #(
  parameter int unsigned GUARD_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic block_i,
  output logic valid_o
);

  localparam int unsigned CW = $clog2(GUARD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(GUARD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || block_i) begin
      cnt_q   <= LOAD;
      valid_o <= 1'b0;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      valid_o <= (cnt_q == '0);
    end
  end

  p_masked_while_blocked_r10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && block_i) |-> !valid_o);

  p_rise_after_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> $past(!block_i));

endmodule

// File: rtl/usb_linestate_xcvr.sv
module usb_linestate_xcvr
  import usb_ls_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned GUARD_NS      = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_oe_n,
  input  logic tx_data,
  input  logic tx_se0,
  input  logic bus_dp,
  input  logic bus_dm,
  input  logic suspend,
  input  logic hiz,
  input  logic vio_ok,
  input  logic v33_ok,
  output logic drv_en,
  output logic drv_dp,
  output logic drv_dm,
  output logic rx_oe,
  output logic rcv,
  output logic se_dp,
  output logic se_dm,
  output logic rcv_valid
);

  localparam int unsigned GUARD_CYC = guard_cycles(GUARD_NS, CLK_PERIOD_PS);

  supply_mode_e mode;
  logic         guard_block;

  assign mode        = decode_mode(vio_ok, v33_ok, hiz);
  assign guard_block = suspend || hiz;

  usb_ls_tx_enc u_tx (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode),
    .oe_n_i   (tx_oe_n),
    .data_i   (tx_data),
    .se0_i    (tx_se0),
    .drv_en_o (drv_en),
    .dp_o     (drv_dp),
    .dm_o     (drv_dm)
  );

  usb_ls_rx_dec u_rx (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode),
    .suspend_i (suspend),
    .dp_i      (bus_dp),
    .dm_i      (bus_dm),
    .rx_oe_o   (rx_oe),
    .vp_o      (se_dp),
    .vm_o      (se_dm),
    .rcv_o     (rcv)
  );

  usb_ls_rx_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk     (clk),
    .rst     (rst),
    .block_i (guard_block),
    .valid_o (rcv_valid)
  );

  p_hiz_release_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && vio_ok && hiz) |-> (!drv_en && !rx_oe && !rcv && !se_dp && !se_dm));

  p_no_vio_release_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !vio_ok) |-> (!drv_en && !rx_oe));

  p_drive_only_normal_r2: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> $past(vio_ok && v33_ok && !hiz && !tx_oe_n));

endmodule

// File: tb/usb_linestate_xcvr_tb.sv
`timescale 1ns/1ps
module usb_linestate_xcvr_tb;

  localparam int unsigned CLK_PS = 4000;
  localparam int unsigned GNS    = 100;
  localparam int          G      = 25;  // ceil(100 ns / 4 ns)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_oe_n = 1'b1, tx_data = 1'b0, tx_se0 = 1'b0;
  logic bus_dp = 1'b1, bus_dm = 1'b0;
  logic suspend = 1'b0, hiz = 1'b0, vio_ok = 1'b1, v33_ok = 1'b1;
  logic drv_en, drv_dp, drv_dm, rx_oe, rcv, se_dp, se_dm, rcv_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  usb_linestate_xcvr #(.CLK_PERIOD_PS(CLK_PS), .GUARD_NS(GNS)) u_dut (
    .clk(clk), .rst(rst), .tx_oe_n(tx_oe_n), .tx_data(tx_data), .tx_se0(tx_se0),
    .bus_dp(bus_dp), .bus_dm(bus_dm), .suspend(suspend), .hiz(hiz),
    .vio_ok(vio_ok), .v33_ok(v33_ok), .drv_en(drv_en), .drv_dp(drv_dp),
    .drv_dm(drv_dm), .rx_oe(rx_oe), .rcv(rcv), .se_dp(se_dp), .se_dm(se_dm),
    .rcv_valid(rcv_valid)
  );

  // [15]oe_n [14]se0 [13]data [12]dp [11]dm [10]suspend [9]hiz [8]vio [7]v33
  // [6]drv_en [5]drv_dp [4]drv_dm [3]rx_oe [2]se_dp [1]se_dm [0]rcv
  localparam logic [15:0] VEC [0:15] = '{
    16'b100100011_0001101, // R3 R4 receive J
    16'b100000011_0001001, // R5 SE0 holds 1
    16'b100010011_0001010, // R4 receive K
    16'b100000011_0001000, // R5 SE0 holds 0
    16'b100110011_0001110, // R5 both high holds 0
    16'b001100011_1101101, // R1 R2 transmit data 1
    16'b000010011_1011010, // R1 transmit data 0
    16'b011000011_1001000, // R1 force SE0 with data 1
    16'b010100011_1001101, // R1 force SE0 with data 0, bus J loads 1
    16'b100101011_0001100, // R6 suspend, J on bus
    16'b100011011_0001010, // R6 suspend, K on bus
    16'b001100010_0001110, // R7 R2 sharing mode
    16'b001100111_0000000, // R8 Hi-Z mode
    16'b001100101_0000000, // R9 no I/O supply, Hi-Z high
    16'b001100001_0000000, // R9 no I/O supply, Hi-Z low
    16'b100000011_0001001  // R5 SE0 after all modes shows pre-suspend value
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {1'b0, drv_en, drv_dp, drv_dm, rx_oe, se_dp, se_dm, rcv};
  endfunction

  task automatic guard_count(input string tag);
    for (int k = 1; k <= G + 1; k++) begin
      @(posedge clk); #1;
      if (k == G)     check({tag, " edge G"},   {7'd0, rcv_valid}, 8'd0);
      if (k == G + 1) check({tag, " edge G+1"}, {7'd0, rcv_valid}, 8'd1);
    end
  endtask

  initial begin
    // R11 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R11 outputs in reset", outs(), 8'd0);
    check("R11 valid in reset", {7'd0, rcv_valid}, 8'd0);
    @(negedge clk) rst = 1'b0;
    guard_count("R10 after reset");

    // vector walk
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      {tx_oe_n, tx_se0, tx_data, bus_dp, bus_dm, suspend, hiz, vio_ok, v33_ok} = VEC[i][15:7];
      @(posedge clk); #1;
      check($sformatf("R1-table row %0d", i), outs(), {1'b0, VEC[i][6:0]});
    end

    // R10 suspend guard
    @(negedge clk);
    {tx_oe_n, tx_se0, tx_data, bus_dp, bus_dm, suspend, hiz, vio_ok, v33_ok} = 9'b100100011;
    suspend = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R10 valid during suspend", {7'd0, rcv_valid}, 8'd0);
    @(negedge clk) suspend = 1'b0;
    guard_count("R10 after suspend");

    // R10 Hi-Z guard
    @(negedge clk) hiz = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R10 valid during Hi-Z", {7'd0, rcv_valid}, 8'd0);
    @(negedge clk) hiz = 1'b0;
    guard_count("R10 after Hi-Z");
    @(posedge clk); #1;
    check("R4 receive J after guard", outs(), 8'b0_0001101);

    // R11 reset returns everything to 0
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check("R11 outputs on re-reset", outs(), 8'd0);
    check("R11 valid on re-reset", {7'd0, rcv_valid}, 8'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule